// File: doc/BRIEF.md
# Serial Bus Controller Interrupt Unit

This block gathers the event lines raised by a serial bus controller core and turns them into one interrupt request for the host. Every event input sets its own bit in a sticky status register. A bit counts as pending only when its enable bit is also set. The request line is the OR of all pending bits, and one global enable bit gates it.

Software reaches the unit through a plain register port. Each write takes effect at the clock edge. Reads come back combinationally from the address. Status bits are cleared by writing ones to them. A write of a fixed key to a separate reset register does two things: it returns the interrupt registers to their reset values, and it sends a reset pulse of fixed length to the controller core.

Each event input can be built in one of two modes, chosen per bit by a parameter mask. In level mode the bit is set on every cycle the input is high. In edge mode the bit is set only on a rising edge of the input.

Top module: `sbc_irq_unit`

## Requirements
- R1: After `rst_n` is released, the status, enable and global-enable registers all read 0, `irq_o` is low and `core_rst_o` is low.
- R2: An event input sets its status bit on the next clock edge, and the bit stays set after the input falls. The status bit positions are: 0 arbitration lost, 1 transmit error or transfer complete, 2 transmit FIFO empty, 3 receive FIFO at threshold, 4 bus idle, 5 selected as target, 6 no longer selected as target, 7 transmit FIFO half empty.
- R3: A write to the status register (offset 0x20) clears each bit written as 1 and leaves each bit written as 0 unchanged.
- R4: If an event sets a status bit in the same cycle that software clears that bit, the bit stays set.
- R5: The enable register (offset 0x28) reads back the bits written to it. `irq_o` is high exactly when some status bit and the matching enable bit are both 1 and the global enable is set.
- R6: The global enable register (offset 0x1C) stores only bit 31, and its other bits read as 0. While that bit is 0, `irq_o` stays low.
- R7: A write of exactly 0x0000000A to the reset register (offset 0x40) clears the status, enable and global-enable registers at that edge. It also drives `core_rst_o` high for `RST_PULSE_LEN` cycles, starting with the cycle after the write. The reset register reads 0.
- R8: A write of any other value to the reset register changes no register and produces no pulse on `core_rst_o`.
- R9: Every address other than 0x1C, 0x20, 0x28 and 0x40 reads 0, and writes to it change nothing.
- R10: An input whose bit is set in `EDGE_MASK` sets its status bit only on a rising edge. If the input stays high after its status bit is cleared, the bit stays clear. An input whose mask bit is 0 sets its status bit again on every cycle it is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | NUM_EVT | Event inputs from the controller core |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | ADDR_W | Byte address of the register |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data for `addr_i` (combinational) |
| irq_o | output | 1 | Interrupt request to the host |
| core_rst_o | output | 1 | Reset pulse to the controller core |

## Verification
The bench builds the unit with eight events, a 7-bit address, `EDGE_MASK` = 0xF0 and a three-cycle reset pulse. This setting places both input modes in one build, so the behaviour of a held input after a clear can be compared between them. With only eight status bits and eight enable bits, the bench can try every enable pattern against every single pending bit, once with the global gate open and once with it closed. The 7-bit address space is small enough to visit every reserved address.

// File: rtl/sbc_irq_pkg.sv
package sbc_irq_pkg;

   typedef enum logic [2:0] {
      SEL_NONE,
      SEL_GIE,
      SEL_ISR,
      SEL_IER,
      SEL_RST
   } irq_sel_e;

   localparam int DEF_OFF_GIE = 'h1C;
   localparam int DEF_OFF_ISR = 'h20;
   localparam int DEF_OFF_IER = 'h28;
   localparam int DEF_OFF_RST = 'h40;
   localparam int DEF_RST_KEY = 'hA;

endpackage

// File: rtl/sbc_irq_decode.sv
module sbc_irq_decode
   import sbc_irq_pkg::*;
#(
   parameter int ADDR_W  = 7,
   parameter int OFF_GIE = DEF_OFF_GIE,
   parameter int OFF_ISR = DEF_OFF_ISR,
   parameter int OFF_IER = DEF_OFF_IER,
   parameter int OFF_RST = DEF_OFF_RST
) (
   input  logic [ADDR_W-1:0] addr_i,
   output irq_sel_e          sel_o
);

   localparam logic [ADDR_W-1:0] A_GIE = ADDR_W'(OFF_GIE);
   localparam logic [ADDR_W-1:0] A_ISR = ADDR_W'(OFF_ISR);
   localparam logic [ADDR_W-1:0] A_IER = ADDR_W'(OFF_IER);
   localparam logic [ADDR_W-1:0] A_RST = ADDR_W'(OFF_RST);

   // full-width compare: unaligned addresses land in the reserved space
   always_comb begin
      if (addr_i == A_GIE)      sel_o = SEL_GIE;
      else if (addr_i == A_ISR) sel_o = SEL_ISR;
      else if (addr_i == A_IER) sel_o = SEL_IER;
      else if (addr_i == A_RST) sel_o = SEL_RST;
      else                      sel_o = SEL_NONE;
   end

endmodule

// File: rtl/sbc_irq_evt_latch.sv
module sbc_irq_evt_latch #(
   parameter int               NUM_EVT   = 8,
   parameter logic [NUM_EVT-1:0] EDGE_MASK = '0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               soft_clr_i,
   input  logic [NUM_EVT-1:0] evt_i,
   input  logic [NUM_EVT-1:0] clr_mask_i,
   output logic [NUM_EVT-1:0] isr_o
);

   logic [NUM_EVT-1:0] hit;

   for (genvar b = 0; b < NUM_EVT; b++) begin : g_bit
      if (EDGE_MASK[b]) begin : g_edge
         logic prev_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) prev_q <= 1'b0;
            else        prev_q <= evt_i[b];
         end
         assign hit[b] = evt_i[b] & ~prev_q;
      end else begin : g_level
         assign hit[b] = evt_i[b];
      end

      // a new event outranks a software clear of the same bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)          isr_o[b] <= 1'b0;
         else if (soft_clr_i) isr_o[b] <= 1'b0;
         else if (hit[b])     isr_o[b] <= 1'b1;
         else if (clr_mask_i[b]) isr_o[b] <= 1'b0;
      end
   end

endmodule

// File: rtl/sbc_irq_soft_rst.sv
module sbc_irq_soft_rst #(
   parameter int DATA_W        = 32,
   parameter int RST_KEY       = 'hA,
   parameter int RST_PULSE_LEN = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_hit_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic              soft_clr_o,
   output logic              core_rst_o
);

   localparam int CNT_W = $clog2(RST_PULSE_LEN + 1);
   localparam logic [DATA_W-1:0] KEY = DATA_W'(RST_KEY);
   localparam logic [CNT_W-1:0]  LEN = CNT_W'(RST_PULSE_LEN);

   logic [CNT_W-1:0] cnt_q;

   assign soft_clr_o = wr_hit_i && (wdata_i == KEY);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                cnt_q <= '0;
      else if (soft_clr_o)       cnt_q <= LEN;
      else if (cnt_q != '0)      cnt_q <= cnt_q - 1'b1;
   end

   assign core_rst_o = (cnt_q != '0);

endmodule

// File: rtl/sbc_irq_unit.sv
module sbc_irq_unit
   import sbc_irq_pkg::*;
#(
   parameter int                 NUM_EVT       = 8,
   parameter int                 ADDR_W        = 7,
   parameter int                 DATA_W        = 32,
   parameter int                 GIE_BIT       = 31,
   parameter logic [NUM_EVT-1:0] EDGE_MASK     = '0,
   parameter int                 RST_KEY       = DEF_RST_KEY,
   parameter int                 RST_PULSE_LEN = 4,
   parameter int                 OFF_GIE       = DEF_OFF_GIE,
   parameter int                 OFF_ISR       = DEF_OFF_ISR,
   parameter int                 OFF_IER       = DEF_OFF_IER,
   parameter int                 OFF_RST       = DEF_OFF_RST
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_EVT-1:0] evt_i,
   input  logic               wr_en_i,
   input  logic [ADDR_W-1:0]  addr_i,
   input  logic [DATA_W-1:0]  wdata_i,
   output logic [DATA_W-1:0]  rdata_o,
   output logic               irq_o,
   output logic               core_rst_o
);

   localparam int ADDR_SPAN = 1 << ADDR_W;

   if (NUM_EVT < 1 || NUM_EVT > DATA_W) begin : g_chk_evt
      $error("NUM_EVT must lie in 1..DATA_W");
   end
   if (GIE_BIT < 0 || GIE_BIT >= DATA_W) begin : g_chk_gie
      $error("GIE_BIT must index a data bit");
   end
   if (RST_PULSE_LEN < 1) begin : g_chk_len
      $error("RST_PULSE_LEN must be at least 1");
   end
   if (OFF_GIE >= ADDR_SPAN || OFF_ISR >= ADDR_SPAN ||
       OFF_IER >= ADDR_SPAN || OFF_RST >= ADDR_SPAN) begin : g_chk_span
      $error("register offset outside the address space");
   end
   if (OFF_GIE == OFF_ISR || OFF_GIE == OFF_IER || OFF_GIE == OFF_RST ||
       OFF_ISR == OFF_IER || OFF_ISR == OFF_RST || OFF_IER == OFF_RST) begin : g_chk_uniq
      $error("register offsets must be distinct");
   end

   irq_sel_e           sel;
   logic               soft_clr;
   logic [NUM_EVT-1:0] clr_mask;
   logic [NUM_EVT-1:0] isr_q;
   logic [NUM_EVT-1:0] ier_q;
   logic               gie_q;

   sbc_irq_decode #(
      .ADDR_W  (ADDR_W),
      .OFF_GIE (OFF_GIE),
      .OFF_ISR (OFF_ISR),
      .OFF_IER (OFF_IER),
      .OFF_RST (OFF_RST)
   ) u_decode (
      .addr_i (addr_i),
      .sel_o  (sel)
   );

   sbc_irq_soft_rst #(
      .DATA_W        (DATA_W),
      .RST_KEY       (RST_KEY),
      .RST_PULSE_LEN (RST_PULSE_LEN)
   ) u_soft_rst (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_hit_i   (wr_en_i && (sel == SEL_RST)),
      .wdata_i    (wdata_i),
      .soft_clr_o (soft_clr),
      .core_rst_o (core_rst_o)
   );

   assign clr_mask = (wr_en_i && (sel == SEL_ISR)) ? wdata_i[NUM_EVT-1:0] : '0;

   sbc_irq_evt_latch #(
      .NUM_EVT   (NUM_EVT),
      .EDGE_MASK (EDGE_MASK)
   ) u_latch (
      .clk        (clk),
      .rst_n      (rst_n),
      .soft_clr_i (soft_clr),
      .evt_i      (evt_i),
      .clr_mask_i (clr_mask),
      .isr_o      (isr_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ier_q <= '0;
         gie_q <= 1'b0;
      end else if (soft_clr) begin
         ier_q <= '0;
         gie_q <= 1'b0;
      end else if (wr_en_i) begin
         if (sel == SEL_IER) ier_q <= wdata_i[NUM_EVT-1:0];
         if (sel == SEL_GIE) gie_q <= wdata_i[GIE_BIT];
      end
   end

   always_comb begin
      rdata_o = '0;
      unique case (sel)
         SEL_GIE: rdata_o[GIE_BIT]       = gie_q;
         SEL_ISR: rdata_o[NUM_EVT-1:0]   = isr_q;
         SEL_IER: rdata_o[NUM_EVT-1:0]   = ier_q;
         default: rdata_o = '0;
      endcase
   end

   assign irq_o = gie_q & (|(isr_q & ier_q));

endmodule

// File: rtl/sbc_irq_chk.sv
module sbc_irq_chk #(
   parameter int                 NUM_EVT   = 8,
   parameter int                 ADDR_W    = 7,
   parameter int                 DATA_W    = 32,
   parameter logic [NUM_EVT-1:0] EDGE_MASK = '0,
   parameter int                 RST_KEY   = 'hA,
   parameter int                 OFF_GIE   = 'h1C,
   parameter int                 OFF_ISR   = 'h20,
   parameter int                 OFF_IER   = 'h28,
   parameter int                 OFF_RST   = 'h40
) (
   input logic               clk,
   input logic               rst_n,
   input logic [NUM_EVT-1:0] evt_i,
   input logic               wr_en_i,
   input logic [ADDR_W-1:0]  addr_i,
   input logic [DATA_W-1:0]  wdata_i,
   input logic [DATA_W-1:0]  rdata_o,
   input logic               irq_o,
   input logic               core_rst_o,
   input logic [NUM_EVT-1:0] isr_q,
   input logic [NUM_EVT-1:0] ier_q,
   input logic               gie_q
);

   localparam logic [ADDR_W-1:0]  A_GIE = ADDR_W'(OFF_GIE);
   localparam logic [ADDR_W-1:0]  A_ISR = ADDR_W'(OFF_ISR);
   localparam logic [ADDR_W-1:0]  A_IER = ADDR_W'(OFF_IER);
   localparam logic [ADDR_W-1:0]  A_RST = ADDR_W'(OFF_RST);
   localparam logic [DATA_W-1:0]  KEY   = DATA_W'(RST_KEY);
   localparam logic [NUM_EVT-1:0] LVL   = ~EDGE_MASK;

   logic key_wr;
   assign key_wr = wr_en_i && (addr_i == A_RST) && (wdata_i == KEY);

   AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en_i && (addr_i == A_ISR || addr_i == A_RST))
      |=> ((isr_q & $past(isr_q)) == $past(isr_q))); // R2

   AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_i && addr_i == A_ISR && evt_i == '0)
      |=> ((isr_q & $past(wdata_i[NUM_EVT-1:0])) == '0)); // R3

   AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (!key_wr && ((evt_i & LVL) != '0))
      |=> ((isr_q & $past(evt_i & LVL)) == $past(evt_i & LVL))); // R4

   AST_GIE_GATES: assert property (@(posedge clk) disable iff (!rst_n)
      !gie_q |-> !irq_o); // R6

   AST_KEY_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      key_wr |=> (isr_q == '0 && ier_q == '0 && !gie_q && core_rst_o)); // R7

   AST_PULSE_FROM_KEY: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(core_rst_o) |-> $past(key_wr)); // R8

   AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (addr_i != A_GIE && addr_i != A_ISR && addr_i != A_IER)
      |-> (rdata_o == '0)); // R9

endmodule

bind sbc_irq_unit sbc_irq_chk #(
   .NUM_EVT   (NUM_EVT),
   .ADDR_W    (ADDR_W),
   .DATA_W    (DATA_W),
   .EDGE_MASK (EDGE_MASK),
   .RST_KEY   (RST_KEY),
   .OFF_GIE   (OFF_GIE),
   .OFF_ISR   (OFF_ISR),
   .OFF_IER   (OFF_IER),
   .OFF_RST   (OFF_RST)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .evt_i      (evt_i),
   .wr_en_i    (wr_en_i),
   .addr_i     (addr_i),
   .wdata_i    (wdata_i),
   .rdata_o    (rdata_o),
   .irq_o      (irq_o),
   .core_rst_o (core_rst_o),
   .isr_q      (isr_q),
   .ier_q      (ier_q),
   .gie_q      (gie_q)
);

// File: tb/sbc_irq_unit_tb.sv
`timescale 1ns/1ps
module sbc_irq_unit_tb;

   localparam int NE  = 8;
   localparam int AW  = 7;
   localparam int DW  = 32;
   localparam int PLS = 3;
   localparam logic [AW-1:0] A_GIE = 7'h1C;
   localparam logic [AW-1:0] A_ISR = 7'h20;
   localparam logic [AW-1:0] A_IER = 7'h28;
   localparam logic [AW-1:0] A_RST = 7'h40;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NE-1:0] evt = '0;
   logic          wr_en = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] wdata = '0;
   logic [DW-1:0] rdata;
   logic          irq;
   logic          core_rst;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   sbc_irq_unit #(
      .NUM_EVT       (NE),
      .ADDR_W        (AW),
      .DATA_W        (DW),
      .EDGE_MASK     (8'hF0),
      .RST_PULSE_LEN (PLS)
   ) u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .evt_i      (evt),
      .wr_en_i    (wr_en),
      .addr_i     (addr),
      .wdata_i    (wdata),
      .rdata_o    (rdata),
      .irq_o      (irq),
      .core_rst_o (core_rst)
   );

   task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 1'b0; wdata = '0;
   endtask

   task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
      addr = a;
      #0.5;
      d = rdata;
   endtask

   task automatic pulse(input logic [NE-1:0] v);
      @(negedge clk);
      evt = v;
      @(negedge clk);
      evt = '0;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   initial begin
      #(5.0 * 100000);
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      logic [DW-1:0] v;
      int cnt;
      idle(4);
      rst_n = 1'b1;
      idle(1);

      // R1 reset state
      rd(A_GIE, v); check("R1 gie", v, 0);
      rd(A_ISR, v); check("R1 isr", v, 0);
      rd(A_IER, v); check("R1 ier", v, 0);
      check("R1 irq", {31'b0, irq}, 0);
      check("R1 core_rst", {31'b0, core_rst}, 0);

      // R2 each event bit latches and stays
      for (int k = 0; k < NE; k++) begin
         wr(A_ISR, 32'hFF);
         pulse(NE'(1 << k));
         rd(A_ISR, v); check("R2 latch", v, 32'(1 << k));
         idle(3);
         rd(A_ISR, v); check("R2 sticky", v, 32'(1 << k));
      end

      // R3 write-one-to-clear
      wr(A_ISR, 32'hFF);
      pulse(8'hFF);
      rd(A_ISR, v); check("R3 all set", v, 32'hFF);
      wr(A_ISR, 32'h00);
      rd(A_ISR, v); check("R3 zero write keeps", v, 32'hFF);
      wr(A_ISR, 32'h5A);
      rd(A_ISR, v); check("R3 partial clear", v, 32'hA5);
      wr(A_ISR, 32'hA5);
      rd(A_ISR, v); check("R3 rest cleared", v, 32'h00);

      // R4 set wins over same-cycle clear (level bit 0, edge bit 4)
      pulse(8'h11);
      @(negedge clk);
      evt = 8'h11; wr_en = 1'b1; addr = A_ISR; wdata = 32'h11;
      @(negedge clk);
      evt = '0; wr_en = 1'b0; wdata = '0;
      rd(A_ISR, v); check("R4 set wins", v, 32'h11);
      wr(A_ISR, 32'hFF);

      // R10 held input after clear: level re-sets, edge does not
      @(negedge clk);
      evt = 8'h22;
      idle(2);
      rd(A_ISR, v); check("R10 both latched", v, 32'h22);
      wr(A_ISR, 32'h22);
      rd(A_ISR, v); check("R10 level resets edge stays", v, 32'h02);
      idle(3);
      rd(A_ISR, v); check("R10 still held", v, 32'h02);
      evt = '0;
      wr(A_ISR, 32'hFF);
      rd(A_ISR, v); check("R10 cleared", v, 32'h00);

      // R6 global enable holds only bit 31
      wr(A_GIE, 32'h7FFF_FFFF);
      rd(A_GIE, v); check("R6 low bits dropped", v, 32'h0);
      wr(A_GIE, 32'hFFFF_FFFF);
      rd(A_GIE, v); check("R6 bit31 only", v, 32'h8000_0000);

      // R5 sweep: every single pending bit against every enable pattern
      for (int k = 0; k < NE; k++) begin
         wr(A_ISR, 32'hFF);
         pulse(NE'(1 << k));
         for (int en = 0; en < 256; en++) begin
            wr(A_IER, 32'(en));
            rd(A_IER, v); check("R5 ier readback", v, 32'(en));
            check("R5 irq", {31'b0, irq}, {31'b0, ((en >> k) & 1) == 1});
         end
      end

      // R6 sweep with gate closed
      wr(A_GIE, 32'h0);
      wr(A_ISR, 32'hFF);
      pulse(8'hFF);
      for (int en = 0; en < 256; en++) begin
         wr(A_IER, 32'(en));
         check("R6 gated", {31'b0, irq}, 0);
      end

      // R9 reserved addresses
      wr(A_GIE, 32'h8000_0000);
      wr(A_IER, 32'h3C);
      wr(A_ISR, 32'h0F);
      for (int a = 0; a < 128; a++) begin
         if (AW'(a) != A_GIE && AW'(a) != A_ISR && AW'(a) != A_IER && AW'(a) != A_RST) begin
            wr(AW'(a), 32'hFFFF_FFFF);
            rd(AW'(a), v); check("R9 reads zero", v, 0);
         end
      end
      rd(A_GIE, v); check("R9 gie kept", v, 32'h8000_0000);
      rd(A_IER, v); check("R9 ier kept", v, 32'h3C);
      rd(A_ISR, v); check("R9 isr kept", v, 32'hF0);
      check("R9 no pulse", {31'b0, core_rst}, 0);

      // R8 wrong keys
      wr(A_RST, 32'hB);
      check("R8 no pulse B", {31'b0, core_rst}, 0);
      wr(A_RST, 32'h1A);
      check("R8 no pulse 1A", {31'b0, core_rst}, 0);
      wr(A_RST, 32'h10A);
      check("R8 no pulse 10A", {31'b0, core_rst}, 0);
      rd(A_GIE, v); check("R8 gie kept", v, 32'h8000_0000);
      rd(A_IER, v); check("R8 ier kept", v, 32'h3C);
      rd(A_ISR, v); check("R8 isr kept", v, 32'hF0);
      check("R8 irq kept", {31'b0, irq}, 1);

      // R7 keyed reset
      @(negedge clk);
      wr_en = 1'b1; addr = A_RST; wdata = 32'hA;
      @(negedge clk);
      wr_en = 1'b0; wdata = '0;
      check("R7 pulse start", {31'b0, core_rst}, 1);
      cnt = 1;
      for (int i = 0; i < 20; i++) begin
         @(negedge clk);
         if (!core_rst) break;
         cnt++;
      end
      check("R7 pulse length", 32'(cnt), 32'(PLS));
      rd(A_GIE, v); check("R7 gie cleared", v, 0);
      rd(A_IER, v); check("R7 ier cleared", v, 0);
      rd(A_ISR, v); check("R7 isr cleared", v, 0);
      rd(A_RST, v); check("R7 reset reg reads zero", v, 0);
      check("R7 irq low", {31'b0, irq}, 0);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule